// File: doc/BRIEF.md
# Multiply Pass Sequencer for Mixed-Capability Vector Lanes

This block is the execution core of a vector unit with `LANES` element lanes, where only `MUL_LANES` of them have a hardware multiplier. Simple arithmetic and logic operations run on every lane at once and produce their results one clock after acceptance. A multiply is split into passes instead. In each pass the available multipliers take the next slice of elements. Upstream logic is held off with a stall flag until the last slice has been written.

An operation is offered with `op_valid`. It carries an opcode, a vector length and two packed operand groups of `LANES` 32-bit elements, with element `i` in bits `[32*i+31:32*i]`. The operation is taken on a rising edge where `op_valid` and `op_ready` are both high. Results leave through a packed result bus that has one write-enable bit per element. When `MUL_LANES` equals `LANES`, a multiply takes one cycle like any other operation.

Top module: `hlm_seq`

## Requirements
- R1: Synchronous reset clears `res_we` and `res_data` to zero, drives `stall` low and `op_ready` high, and abandons any multiply in progress.
- R2: Opcodes 0 (a+b), 1 (a-b), 2 (a AND b), 3 (a OR b) and 4 (a XOR b) are computed on all lanes and registered on the edge that accepts them. `stall` stays low and `op_ready` stays high.
- R3: Opcodes 6 and 7 write zero into every enabled element.
- R4: Opcode 5 writes the low 32 bits of the signed product of the two elements.
- R5: With `MUL_LANES` < `LANES`, a multiply takes P = ceil(LANES/MUL_LANES) passes. In pass p, multiplier k serves element p*MUL_LANES+k. The elements of pass p are written on the (p+1)-th edge after the accepting edge, and only those elements are enabled on that edge.
- R6: For a multiply that needs more than one pass, `stall` is high in the cycle the multiply is offered. It stays high until the edge that writes the last pass. `op_ready` is low for exactly the P cycles between the accepting edge and that edge.
- R7: An operation offered while `op_ready` is low is ignored. It produces no write enable, either during the multiply or afterwards.
- R8: Element i gets a write enable only if i < `op_vlen`. A length of 0 enables nothing, and a multiply with that length still runs all its passes.
- R9: An element whose write enable is low on an edge keeps its previous `res_data` value.
- R10: With `MUL_LANES` = `LANES`, a multiply behaves like R2: all elements are written on the accepting edge and `stall` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_code | input | 3 | Operation code (see R2-R4) |
| op_vlen | input | VLEN_W | Number of active elements |
| op_a | input | LANES*32 | First operand elements, packed |
| op_b | input | LANES*32 | Second operand elements, packed |
| op_ready | output | 1 | An offered operation is taken on the next edge |
| stall | output | 1 | Hold-off to upstream while a split multiply is pending |
| res_data | output | LANES*32 | Result elements, packed |
| res_we | output | LANES | Per-element write enable |

## Verification
A pass counter that is off by one shows up on the port side within one edge. Either the write-enable pattern selects the wrong pair of lanes, or `op_ready` returns a cycle early or late, so the stall window no longer spans P cycles. A corrupted operand latch or a wrong multiplier route produces a wrong product on the very edge that writes that pass. A faulty length mask or hold path shows up as an enable beyond the length, or as data that changes on a lane with no enable. Reset in the middle of a multiply checks that the pending passes vanish on the next edge.

// File: rtl/hlm_pkg.sv
`timescale 1ns/1ps
package hlm_pkg;

    localparam int LANE_W = 32;

    typedef logic [LANE_W-1:0] lane_t;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_MUL  = 3'd5,
        OP_NIL6 = 3'd6,
        OP_NIL7 = 3'd7
    } hlm_op_e;

    function automatic int pass_count(int lanes, int mul_lanes);
        return (lanes + mul_lanes - 1) / mul_lanes;
    endfunction

    // Non-multiply lane operation; multiply is handled by the pass datapath.
    function automatic lane_t alu_eval(hlm_op_e op, lane_t a, lane_t b);
        case (op)
            OP_ADD:  return a + b;
            OP_SUB:  return a - b;
            OP_AND:  return a & b;
            OP_OR:   return a | b;
            OP_XOR:  return a ^ b;
            default: return '0;
        endcase
    endfunction

    function automatic lane_t mul_low(lane_t a, lane_t b);
        logic signed [2*LANE_W-1:0] full;
        full = $signed(a) * $signed(b);
        return full[LANE_W-1:0];
    endfunction

endpackage

// File: rtl/hlm_alu_lanes.sv
`timescale 1ns/1ps
module hlm_alu_lanes
    import hlm_pkg::*;
#(
    parameter int LANES = 4
) (
    input  hlm_op_e op,
    input  lane_t   a [LANES],
    input  lane_t   b [LANES],
    output lane_t   y [LANES]
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign y[i] = alu_eval(op, a[i], b[i]);
    end

endmodule

// File: rtl/hlm_mul_router.sv
`timescale 1ns/1ps
module hlm_mul_router
    import hlm_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int MUL_LANES = 2,
    parameter int PASS_W    = 1
) (
    input  logic [PASS_W-1:0] pass,
    input  lane_t             a [LANES],
    input  lane_t             b [LANES],
    output logic [LANES-1:0]  lane_hit,
    output lane_t             lane_prod [LANES]
);

    lane_t prod [MUL_LANES];

    // Multiplier k takes element pass*MUL_LANES + k of the group.
    for (genvar k = 0; k < MUL_LANES; k++) begin : g_mul
        lane_t a_sel, b_sel;
        always_comb begin
            a_sel = '0;
            b_sel = '0;
            for (int j = 0; j < LANES; j++) begin
                if (int'(pass) * MUL_LANES + k == j) begin
                    a_sel = a[j];
                    b_sel = b[j];
                end
            end
        end
        assign prod[k] = mul_low(a_sel, b_sel);
    end

    // Scatter products back to their element positions.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_hit[i]  = (int'(pass) == i / MUL_LANES);
        assign lane_prod[i] = prod[i % MUL_LANES];
    end

endmodule

// File: rtl/hlm_pass_ctrl.sv
`timescale 1ns/1ps
module hlm_pass_ctrl #(
    parameter int PASSES = 2,
    parameter int PASS_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic [PASS_W-1:0] pass
);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            pass <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                pass <= '0;
            end
        end else if (int'(pass) == PASSES - 1) begin
            busy <= 1'b0;
            pass <= '0;
        end else begin
            pass <= pass + 1'b1;
        end
    end

endmodule

// File: rtl/hlm_seq.sv
`timescale 1ns/1ps
module hlm_seq
    import hlm_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int MUL_LANES = 2,
    parameter int VLEN_W    = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    op_valid,
    input  logic [2:0]              op_code,
    input  logic [VLEN_W-1:0]       op_vlen,
    input  logic [LANES*LANE_W-1:0] op_a,
    input  logic [LANES*LANE_W-1:0] op_b,
    output logic                    op_ready,
    output logic                    stall,
    output logic [LANES*LANE_W-1:0] res_data,
    output logic [LANES-1:0]        res_we
);

    localparam int   PASSES = pass_count(LANES, MUL_LANES);
    localparam logic SPLIT  = (PASSES > 1);
    localparam int   PASS_W = (PASSES > 1) ? $clog2(PASSES) : 1;

    lane_t a_in [LANES];
    lane_t b_in [LANES];
    lane_t m_a [LANES];
    lane_t m_b [LANES];
    lane_t alu_y [LANES];
    lane_t lane_prod [LANES];
    lane_t out_q [LANES];

    hlm_op_e            op_e;
    logic               is_mul;
    logic               busy;
    logic               accept;
    logic [PASS_W-1:0]  pass;
    logic [LANES-1:0]   lane_hit;
    logic [LANES-1:0]   we_q;
    logic [VLEN_W-1:0]  vlen_q;

    for (genvar i = 0; i < LANES; i++) begin : g_pack
        assign a_in[i] = op_a[i*LANE_W +: LANE_W];
        assign b_in[i] = op_b[i*LANE_W +: LANE_W];
        assign res_data[i*LANE_W +: LANE_W] = out_q[i];
    end

    assign op_e     = hlm_op_e'(op_code);
    assign is_mul   = (op_e == OP_MUL);
    assign op_ready = !busy;
    assign accept   = op_valid && !busy;
    assign stall    = busy || (SPLIT && op_valid && is_mul);
    assign res_we   = we_q;

    if (SPLIT) begin : g_split
        lane_t a_q [LANES];
        lane_t b_q [LANES];

        hlm_pass_ctrl #(
            .PASSES (PASSES),
            .PASS_W (PASS_W)
        ) u_ctrl (
            .clk   (clk),
            .rst   (rst),
            .start (accept && is_mul),
            .busy  (busy),
            .pass  (pass)
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                vlen_q <= '0;
                for (int i = 0; i < LANES; i++) begin
                    a_q[i] <= '0;
                    b_q[i] <= '0;
                end
            end else if (accept && is_mul) begin
                vlen_q <= op_vlen;
                a_q    <= a_in;
                b_q    <= b_in;
            end
        end

        assign m_a = a_q;
        assign m_b = b_q;
    end else begin : g_flat
        assign busy   = 1'b0;
        assign pass   = '0;
        assign vlen_q = op_vlen;
        assign m_a    = a_in;
        assign m_b    = b_in;
    end

    hlm_alu_lanes #(
        .LANES (LANES)
    ) u_alu (
        .op (op_e),
        .a  (a_in),
        .b  (b_in),
        .y  (alu_y)
    );

    hlm_mul_router #(
        .LANES     (LANES),
        .MUL_LANES (MUL_LANES),
        .PASS_W    (PASS_W)
    ) u_mul (
        .pass      (pass),
        .a         (m_a),
        .b         (m_b),
        .lane_hit  (lane_hit),
        .lane_prod (lane_prod)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q <= '0;
            for (int i = 0; i < LANES; i++) out_q[i] <= '0;
        end else begin
            we_q <= '0;
            if (accept && !(SPLIT && is_mul)) begin
                for (int i = 0; i < LANES; i++) begin
                    if (i < int'(op_vlen)) begin
                        out_q[i] <= is_mul ? lane_prod[i] : alu_y[i];
                        we_q[i]  <= 1'b1;
                    end
                end
            end else if (busy) begin
                for (int i = 0; i < LANES; i++) begin
                    if (lane_hit[i] && i < int'(vlen_q)) begin
                        out_q[i] <= lane_prod[i];
                        we_q[i]  <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/hlm_seq_chk.sv
`timescale 1ns/1ps
module hlm_seq_chk
    import hlm_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int MUL_LANES = 2,
    parameter int VLEN_W    = $clog2(LANES + 1)
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    op_valid,
    input logic [2:0]              op_code,
    input logic [VLEN_W-1:0]       op_vlen,
    input logic                    op_ready,
    input logic                    stall,
    input logic [LANES*LANE_W-1:0] res_data,
    input logic [LANES-1:0]        res_we
);

    localparam int PASSES = pass_count(LANES, MUL_LANES);

    function automatic logic [LANES-1:0] len_mask(logic [VLEN_W-1:0] v);
        logic [LANES-1:0] m;
        for (int i = 0; i < LANES; i++) m[i] = (i < int'(v));
        return m;
    endfunction

    function automatic logic [LANES*LANE_W-1:0] spread(logic [LANES-1:0] we);
        logic [LANES*LANE_W-1:0] m;
        for (int i = 0; i < LANES; i++) m[i*LANE_W +: LANE_W] = {LANE_W{we[i]}};
        return m;
    endfunction

    int unsigned hold_run;
    always_ff @(posedge clk) begin
        if (rst)            hold_run <= 0;
        else if (!op_ready) hold_run <= hold_run + 1;
        else                hold_run <= 0;
    end

    p_ready_stall_r6: assert property (@(posedge clk) disable iff (rst)
        !op_ready |-> stall);

    p_hold_len_r6: assert property (@(posedge clk) disable iff (rst)
        hold_run <= PASSES);

    p_alu_nostall_r2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && op_code != 3'd5) |-> !stall);

    p_alu_ready_r2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && op_code != 3'd5) |=> op_ready);

    p_we_len_r8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready) |=> ((res_we & ~len_mask($past(op_vlen))) == '0));

    p_pass_width_r5: assert property (@(posedge clk) disable iff (rst)
        !op_ready |-> ($countones(res_we) <= MUL_LANES));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (op_ready && !op_valid) |=> (res_we == '0));

    p_keep_data_r9: assert property (@(posedge clk) disable iff (rst)
        (((res_data ^ $past(res_data)) & ~spread(res_we)) == '0));

endmodule

bind hlm_seq hlm_seq_chk #(
    .LANES     (LANES),
    .MUL_LANES (MUL_LANES),
    .VLEN_W    (VLEN_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_vlen  (op_vlen),
    .op_ready (op_ready),
    .stall    (stall),
    .res_data (res_data),
    .res_we   (res_we)
);

// File: tb/hlm_seq_test.sv
`timescale 1ns/1ps
module hlm_seq_test;

    localparam int L  = 4;
    localparam int X  = 2;
    localparam int NP = (L + X - 1) / X;
    localparam int NV = 10;

    logic           clk = 1'b0;
    logic           rst;
    logic           op_valid;
    logic [2:0]     op_code;
    logic [2:0]     op_vlen;
    logic [L*32-1:0] op_a, op_b;
    logic           op_ready, stall;
    logic [L*32-1:0] res_data;
    logic [L-1:0]   res_we;
    logic           f_ready, f_stall;
    logic [L*32-1:0] f_data;
    logic [L-1:0]   f_we;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] shadow [L];

    always #2.5 clk = ~clk;

    hlm_seq #(.LANES(L), .MUL_LANES(X)) uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_vlen(op_vlen), .op_a(op_a), .op_b(op_b), .op_ready(op_ready),
        .stall(stall), .res_data(res_data), .res_we(res_we));

    hlm_seq #(.LANES(L), .MUL_LANES(L)) uut_full (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_vlen(op_vlen), .op_a(op_a), .op_b(op_b), .op_ready(f_ready),
        .stall(f_stall), .res_data(f_data), .res_we(f_we));

    // Stimulus table: opcode, length, operands (element 3 first).
    localparam logic [2:0] T_OP [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4,
                                         3'd5, 3'd5, 3'd6, 3'd5, 3'd7};
    localparam logic [2:0] T_LEN [NV] = '{3'd4, 3'd3, 3'd4, 3'd2, 3'd1,
                                          3'd4, 3'd3, 3'd4, 3'd0, 3'd0};
    localparam logic [127:0] T_A [NV] = '{
        {32'h7fffffff, 32'h0000000a, 32'h00000001, 32'hffffffff},
        {32'h00000005, 32'h00000000, 32'h00000064, 32'h00000003},
        {32'hf0f0f0f0, 32'h12345678, 32'hffffffff, 32'h0000ffff},
        {32'h11111111, 32'h22222222, 32'h0f000000, 32'h00000010},
        {32'haaaaaaaa, 32'h55555555, 32'h12121212, 32'hdeadbeef},
        {32'hfffffffd, 32'h80000000, 32'h00010000, 32'h00000007},
        {32'h00000009, 32'hfffffff0, 32'h7fffffff, 32'hffffffff},
        {32'h13572468, 32'h0badf00d, 32'h00000001, 32'hcafef00d},
        {32'h00000003, 32'h00000004, 32'h00000005, 32'h00000006},
        {32'h01020304, 32'h05060708, 32'h090a0b0c, 32'h0d0e0f10}};
    localparam logic [127:0] T_B [NV] = '{
        {32'h00000001, 32'h00000005, 32'h00000002, 32'h00000001},
        {32'h00000006, 32'h00000001, 32'h00000001, 32'h00000003},
        {32'h0ff00ff0, 32'hffff0000, 32'h00000000, 32'h00ff00ff},
        {32'h00000001, 32'h00000002, 32'h000000f0, 32'h00000001},
        {32'h55555555, 32'h55555555, 32'h21212121, 32'hffffffff},
        {32'h00000007, 32'h00000002, 32'h00010000, 32'hfffffffe},
        {32'h00000009, 32'hfffffff0, 32'h00000002, 32'hffffffff},
        {32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444},
        {32'h00000002, 32'h00000002, 32'h00000002, 32'h00000002},
        {32'h00000001, 32'h00000001, 32'h00000001, 32'h00000001}};

    function automatic logic [31:0] ref_lane(logic [2:0] op, logic [31:0] a, logic [31:0] b);
        logic signed [63:0] p;
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            3'd5: begin p = $signed(a) * $signed(b); return p[31:0]; end
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [L-1:0] len_mask(logic [2:0] v);
        logic [L-1:0] m;
        for (int i = 0; i < L; i++) m[i] = (i < int'(v));
        return m;
    endfunction

    function automatic logic [L-1:0] pass_mask(int p);
        logic [L-1:0] m;
        for (int i = 0; i < L; i++) m[i] = (i / X == p);
        return m;
    endfunction

    function automatic logic [L*32-1:0] shadow_bus();
        logic [L*32-1:0] v;
        for (int i = 0; i < L; i++) v[i*32 +: 32] = shadow[i];
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [2:0] vlen,
                          input logic [127:0] a, input logic [127:0] b);
        logic [L-1:0] ew;
        @(negedge clk);
        op_valid = 1'b1; op_code = op; op_vlen = vlen; op_a = a; op_b = b;
        #1;
        chk(stall == (op == 3'd5), "R6 R2 stall at offer", 128'(stall), 128'(op == 3'd5));
        chk(op_ready == 1'b1, "R2 ready at offer", 128'(op_ready), 128'd1);
        @(posedge clk);
        @(negedge clk);
        if (op != 3'd5) begin
            op_valid = 1'b0;
            ew = len_mask(vlen);
            for (int i = 0; i < L; i++)
                if (ew[i]) shadow[i] = ref_lane(op, a[i*32 +: 32], b[i*32 +: 32]);
            chk(res_we == ew, "R8 R2 write enables", 128'(res_we), 128'(ew));
            chk(res_data == shadow_bus(), "R2 R3 R9 result data", res_data, shadow_bus());
            chk(stall == 1'b0 && op_ready == 1'b1, "R2 no stall",
                128'({stall, op_ready}), 128'b01);
        end else begin
            // R7: offer an add while busy; it must leave no trace.
            op_code = 3'd0; op_a = ~a;
            chk(stall == 1'b1 && op_ready == 1'b0, "R6 stall after accept",
                128'({stall, op_ready}), 128'b10);
            chk(res_we == '0, "R5 no write on accept edge", 128'(res_we), 128'd0);
            for (int p = 0; p < NP; p++) begin
                @(negedge clk);
                ew = pass_mask(p) & len_mask(vlen);
                for (int i = 0; i < L; i++)
                    if (ew[i]) shadow[i] = ref_lane(3'd5, a[i*32 +: 32], b[i*32 +: 32]);
                chk(res_we == ew, "R5 R8 pass enables", 128'(res_we), 128'(ew));
                chk(res_data == shadow_bus(), "R4 R9 pass data", res_data, shadow_bus());
                chk(stall == (p < NP - 1) && op_ready == (p == NP - 1), "R6 stall window",
                    128'({stall, op_ready}), 128'({p < NP - 1, p == NP - 1}));
            end
            op_valid = 1'b0;
            @(negedge clk);
            chk(res_we == '0, "R7 offer during stall ignored", 128'(res_we), 128'd0);
            chk(res_data == shadow_bus(), "R7 R9 data kept", res_data, shadow_bus());
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_code = '0; op_vlen = '0; op_a = '0; op_b = '0;
        for (int i = 0; i < L; i++) shadow[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(res_we == '0 && res_data == '0, "R1 reset outputs", res_data, 128'd0);
        chk(stall == 1'b0 && op_ready == 1'b1, "R1 reset flags",
            128'({stall, op_ready}), 128'b01);

        for (int v = 0; v < NV; v++) run_op(T_OP[v], T_LEN[v], T_A[v], T_B[v]);

        // R10: full multiplier complement, single-cycle multiply.
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd5; op_vlen = 3'd4;
        op_a = {32'hfffffffb, 32'h00000003, 32'h40000000, 32'h0000000b};
        op_b = {32'hfffffffb, 32'hfffffff9, 32'h00000004, 32'h0000000d};
        #1;
        chk(f_stall == 1'b0, "R10 no stall", 128'(f_stall), 128'd0);
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        chk(f_we == 4'hf, "R10 all enables", 128'(f_we), 128'hf);
        for (int i = 0; i < L; i++)
            chk(f_data[i*32 +: 32] == ref_lane(3'd5, op_a[i*32 +: 32], op_b[i*32 +: 32]),
                "R10 R4 product", 128'(f_data[i*32 +: 32]),
                128'(ref_lane(3'd5, op_a[i*32 +: 32], op_b[i*32 +: 32])));
        repeat (3) @(negedge clk);

        // R1: reset in the middle of a split multiply.
        op_valid = 1'b1; op_code = 3'd5; op_vlen = 3'd4;
        op_a = {4{32'h00000003}}; op_b = {4{32'h00000005}};
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0; rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(res_we == '0 && res_data == '0, "R1 reset mid multiply data", res_data, 128'd0);
        chk(stall == 1'b0 && op_ready == 1'b1, "R1 reset mid multiply flags",
            128'({stall, op_ready}), 128'b01);
        rst = 1'b0;
        for (int i = 0; i < L; i++) shadow[i] = '0;
        run_op(3'd0, 3'd4, {32'd1, 32'd2, 32'd3, 32'd4}, {32'd10, 32'd20, 32'd30, 32'd40});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule